// File: doc/BRIEF.md
# Single-Channel Memory Copy Sequencer with Bus Fault Recovery

This block moves a run of 32-bit words from a source region to a destination region over a simple bus master port. A start strobe loads a descriptor: source and destination addresses, a signed step for each, and a byte count. The block then runs the copy one word at a time. It issues a read, holds the returned word in a one-word buffer, and then issues a write of that word. After each successful read it steps the source address. After each successful write it steps the destination address and takes one word's worth of bytes off the count. When the count runs out it raises a one-cycle completion pulse.

The bus carries one request at a time. The request stays up until the responder answers with either a completion or an error. An error answer stops the copy and sets a sticky fault flag for the side that failed. The side that did not fail still gets one closing beat. After a faulted read, the paired write goes out carrying whatever word came back with the error. After a faulted write with words still left, one more read goes out. The block then parks in a halted state. Its descriptor outputs show the source address, destination address and remaining count as they stood when the fault occurred. The flags and the halted state stay until an explicit clear.

Top module: `dmaseq_mover`

## Requirements
- R1: While reset is held and after its release, the block is idle: no bus request, `busy`, `done` and `halted` low, both fault flags clear.
- R2: After a start, each word is moved as one read at `desc_src` followed by one write at `desc_dst`. The write carries the word just read. After a successful read the source address grows by the source step, and after a successful write the destination address grows by the destination step. Each step is a 16-bit two's-complement value, sign-extended to the address width.
- R3: `bus_req` is held, with `bus_addr`, `bus_we` and `bus_wdata` unchanged, until a cycle in which `bus_done` or `bus_err` is high. Only one request is open at a time. `bus_we` is 1 for writes and 0 for reads.
- R4: Each successful write takes 4 off the byte count. When the count reaches zero, `done` is high for exactly one cycle and `desc_cnt` reads 0. A start with a byte count of 0 gives the `done` pulse with no bus traffic.
- R5: An error answer to a read sets `src_err`. The paired write is still issued, carrying the `bus_rdata` value seen with the error. The block then halts with `desc_src` at the failed read address and `desc_dst` and `desc_cnt` as they stood before that write.
- R6: An error answer to a write, with more than 4 bytes left, sets `dst_err`. One more read is issued at the current source address, and then the block halts. It keeps `desc_src` past the last good read, `desc_dst` at the failed write address and `desc_cnt` not reduced.
- R7: An error answer to the write of the final word halts the block at once, with no further read.
- R8: `src_err`, `dst_err` and `halted` stay set until `err_clr` is high for a cycle. That clear returns a halted block to idle. If a clear and an error answer fall in the same cycle, the flag ends up set.
- R9: A start strobe has no effect while a copy is running or while the block is halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the descriptor and begin (idle only) |
| cfg_src | input | ADDR_W | First source address |
| cfg_dst | input | ADDR_W | First destination address |
| cfg_src_step | input | OFF_W | Signed source step |
| cfg_dst_step | input | OFF_W | Signed destination step |
| cfg_bytes | input | CNT_W | Bytes to move |
| err_clr | input | 1 | Clear fault flags and leave the halted state |
| bus_req | output | 1 | Bus request, held until answered |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data |
| bus_done | input | 1 | Request finished without error |
| bus_err | input | 1 | Request finished with an error |
| busy | output | 1 | Read or write phase in progress |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Stopped after a fault |
| src_err | output | 1 | Sticky read fault flag |
| dst_err | output | 1 | Sticky write fault flag |
| desc_src | output | ADDR_W | Live or fault-time source address |
| desc_dst | output | ADDR_W | Live or fault-time destination address |
| desc_cnt | output | CNT_W | Live or fault-time remaining bytes |

## Verification
The two functions that can land on the same clock edge are the setting of a fault flag by an error answer and the clearing of that flag by `err_clr`. The bench's bus responder raises `err_clr` in exactly the cycle in which it drives an error answer to a read. The case is judged by `src_err` staying high afterwards, because set has priority over clear. A separate scenario raises `err_clr` alone while the block is halted and expects both flags and `halted` to drop. This shows that the priority does not come from a clear that never works.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_READ  = 3'd1,
      ST_WRITE = 3'd2,
      ST_DONE  = 3'd3,
      ST_ERROR = 3'd4
   } seq_state_e;
endpackage

// File: rtl/dmaseq_ptr.sv
// Address register with its own signed step; loads at start, steps on adv.
module dmaseq_ptr #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [OFF_W-1:0]  load_step,
   input  logic              adv,
   output logic [ADDR_W-1:0] ptr
);
   logic [OFF_W-1:0]  step_q;
   logic [ADDR_W-1:0] step_ext;

   generate
      if (OFF_W > ADDR_W) begin : g_bad_step
         $error("dmaseq_ptr: OFF_W must not exceed ADDR_W");
      end else if (OFF_W == ADDR_W) begin : g_full_step
         assign step_ext = step_q;
      end else begin : g_sext_step
         assign step_ext = {{(ADDR_W-OFF_W){step_q[OFF_W-1]}}, step_q};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         step_q <= '0;
      end else if (load) begin
         ptr    <= load_addr;
         step_q <= load_step;
      end else if (adv) begin
         ptr    <= ptr + step_ext;
      end
   end
endmodule

// File: rtl/dmaseq_count.sv
// Remaining-byte counter; one beat's bytes come off per successful write.
module dmaseq_count #(
   parameter int CNT_W      = 16,
   parameter int BEAT_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_cnt,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   localparam logic [CNT_W-1:0] STEP_C = CNT_W'(BEAT_BYTES);

   generate
      if (BEAT_BYTES < 1 || BEAT_BYTES >= (1 << (CNT_W-1))) begin : g_bad_beat
         $error("dmaseq_count: beat size does not fit the counter");
      end
   endgenerate

   assign last = (cnt <= STEP_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_cnt;
      end else if (dec) begin
         cnt <= last ? '0 : cnt - STEP_C;
      end
   end
endmodule

// File: rtl/dmaseq_errflags.sv
// Sticky fault flags; a set in the same cycle as a clear wins.
module dmaseq_errflags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_src,
   input  logic set_dst,
   input  logic clr,
   output logic src_err,
   output logic dst_err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_err <= 1'b0;
         dst_err <= 1'b0;
      end else begin
         src_err <= set_src | (src_err & ~clr);
         dst_err <= set_dst | (dst_err & ~clr);
      end
   end
endmodule

// File: rtl/dmaseq_fsm.sv
// Beat sequencer: read, write, repeat; a fault arms one closing beat, then halt.
module dmaseq_fsm
   import dmaseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       cfg_empty,
   input  logic       cnt_last,
   input  logic       bus_done,
   input  logic       bus_err,
   input  logic       err_clr,
   output seq_state_e state,
   output logic       load,
   output logic       src_adv,
   output logic       dst_adv,
   output logic       cnt_dec,
   output logic       cap,
   output logic       set_src_err,
   output logic       set_dst_err
);
   seq_state_e nxt;
   logic       trail_q;
   logic       trail_set;
   logic       rsp;

   assign rsp = bus_done | bus_err;

   always_comb begin
      nxt         = state;
      load        = 1'b0;
      src_adv     = 1'b0;
      dst_adv     = 1'b0;
      cnt_dec     = 1'b0;
      cap         = 1'b0;
      set_src_err = 1'b0;
      set_dst_err = 1'b0;
      trail_set   = 1'b0;
      case (state)
         ST_IDLE: begin
            if (start) begin
               load = 1'b1;
               nxt  = cfg_empty ? ST_DONE : ST_READ;
            end
         end
         ST_READ: begin
            if (rsp) begin
               cap         = 1'b1;
               set_src_err = bus_err;
               if (trail_q) begin
                  nxt = ST_ERROR;
               end else begin
                  nxt = ST_WRITE;
                  if (bus_err) trail_set = 1'b1;
                  else         src_adv   = 1'b1;
               end
            end
         end
         ST_WRITE: begin
            if (rsp) begin
               set_dst_err = bus_err;
               if (trail_q) begin
                  nxt = ST_ERROR;
               end else if (bus_err) begin
                  if (cnt_last) begin
                     nxt = ST_ERROR;
                  end else begin
                     trail_set = 1'b1;
                     nxt       = ST_READ;
                  end
               end else begin
                  dst_adv = 1'b1;
                  cnt_dec = 1'b1;
                  nxt     = cnt_last ? ST_DONE : ST_READ;
               end
            end
         end
         ST_DONE:  nxt = ST_IDLE;
         ST_ERROR: if (err_clr) nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         trail_q <= 1'b0;
      end else begin
         state <= nxt;
         if (load)           trail_q <= 1'b0;
         else if (trail_set) trail_q <= 1'b1;
      end
   end
endmodule

// File: rtl/dmaseq_mover.sv
module dmaseq_mover
   import dmaseq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 16,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] cfg_src,
   input  logic [ADDR_W-1:0] cfg_dst,
   input  logic [OFF_W-1:0]  cfg_src_step,
   input  logic [OFF_W-1:0]  cfg_dst_step,
   input  logic [CNT_W-1:0]  cfg_bytes,
   input  logic              err_clr,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_done,
   input  logic              bus_err,
   output logic              busy,
   output logic              done,
   output logic              halted,
   output logic              src_err,
   output logic              dst_err,
   output logic [ADDR_W-1:0] desc_src,
   output logic [ADDR_W-1:0] desc_dst,
   output logic [CNT_W-1:0]  desc_cnt
);
   localparam int BEAT_BYTES = DATA_W / 8;

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data
         $error("dmaseq_mover: DATA_W must be a whole number of bytes");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("dmaseq_mover: ADDR_W too small");
      end
   endgenerate

   seq_state_e        state;
   logic              load, src_adv, dst_adv, cnt_dec, cap;
   logic              set_src_err, set_dst_err;
   logic              cnt_last;
   logic [DATA_W-1:0] word_q;

   dmaseq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .cfg_empty   (cfg_bytes == '0),
      .cnt_last    (cnt_last),
      .bus_done    (bus_done),
      .bus_err     (bus_err),
      .err_clr     (err_clr),
      .state       (state),
      .load        (load),
      .src_adv     (src_adv),
      .dst_adv     (dst_adv),
      .cnt_dec     (cnt_dec),
      .cap         (cap),
      .set_src_err (set_src_err),
      .set_dst_err (set_dst_err)
   );

   dmaseq_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_src_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (cfg_src),
      .load_step (cfg_src_step),
      .adv       (src_adv),
      .ptr       (desc_src)
   );

   dmaseq_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dst_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_addr (cfg_dst),
      .load_step (cfg_dst_step),
      .adv       (dst_adv),
      .ptr       (desc_dst)
   );

   dmaseq_count #(.CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_cnt (cfg_bytes),
      .dec      (cnt_dec),
      .cnt      (desc_cnt),
      .last     (cnt_last)
   );

   dmaseq_errflags u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_src (set_src_err),
      .set_dst (set_dst_err),
      .clr     (err_clr),
      .src_err (src_err),
      .dst_err (dst_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (cap) word_q <= bus_rdata;
   end

   assign bus_req   = (state == ST_READ) || (state == ST_WRITE);
   assign bus_we    = (state == ST_WRITE);
   assign bus_addr  = bus_we ? desc_dst : desc_src;
   assign bus_wdata = word_q;
   assign busy      = bus_req;
   assign done      = (state == ST_DONE);
   assign halted    = (state == ST_ERROR);
endmodule

// File: rtl/dmaseq_mover_chk.sv
module dmaseq_mover_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              err_clr,
   input logic              bus_req,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_done,
   input logic              bus_err,
   input logic              busy,
   input logic              done,
   input logic              halted,
   input logic              src_err,
   input logic              dst_err,
   input logic [CNT_W-1:0]  desc_cnt
);
   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_done && !bus_err |=>
         bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> desc_cnt == '0);

   // R5
   src_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_we && bus_err |=> src_err);

   // R6
   dst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_we && bus_err |=> dst_err);

   // R5
   fault_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_err |=> $stable(desc_cnt));

   // R8
   src_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_err && !err_clr |=> src_err);

   // R8
   dst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_err && !err_clr |=> dst_err);

   // R8
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted && !err_clr |=> halted);

   // R8
   halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !bus_req && !busy && !done);
endmodule

bind dmaseq_mover dmaseq_mover_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .err_clr   (err_clr),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_done  (bus_done),
   .bus_err   (bus_err),
   .busy      (busy),
   .done      (done),
   .halted    (halted),
   .src_err   (src_err),
   .dst_err   (dst_err),
   .desc_cnt  (desc_cnt)
);

// File: tb/dmaseq_mover_tb.sv
`timescale 1ns/1ps
module dmaseq_mover_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] cfg_src = '0, cfg_dst = '0;
   logic [15:0] cfg_src_step = '0, cfg_dst_step = '0, cfg_bytes = '0;
   logic        tb_clr = 1'b0, coll_clr = 1'b0;
   logic        err_clr;
   logic        bus_req, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic        bus_done = 1'b0, bus_err = 1'b0;
   logic        busy, done, halted, src_err, dst_err;
   logic [31:0] desc_src, desc_dst;
   logic [15:0] desc_cnt;

   assign err_clr = tb_clr | coll_clr;

   dmaseq_mover u_dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .cfg_src(cfg_src), .cfg_dst(cfg_dst),
      .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step), .cfg_bytes(cfg_bytes),
      .err_clr(err_clr),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_err(bus_err),
      .busy(busy), .done(done), .halted(halted), .src_err(src_err), .dst_err(dst_err),
      .desc_src(desc_src), .desc_dst(desc_dst), .desc_cnt(desc_cnt)
   );

   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // bus responder state
   logic [31:0] mem [64];
   int          lat = 0, err_at = -1, txn = 0, wcnt = 0, r3_viol = 0;
   bit          coll = 1'b0;
   logic        log_we   [64];
   logic [31:0] log_addr [64];
   logic [31:0] log_data [64];
   logic [31:0] hold_addr;
   logic        hold_we;

   function automatic logic [31:0] seed_word(input int i);
      return {8'hA5, 8'(i), 16'(i * 3 + 7)};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   initial begin
      forever begin
         @(negedge clk);
         if (bus_done || bus_err) begin
            bus_done = 1'b0; bus_err = 1'b0; coll_clr = 1'b0; wcnt = 0;
         end else if (bus_req) begin
            if (wcnt == 0) begin
               hold_addr = bus_addr; hold_we = bus_we;
            end else if (bus_addr !== hold_addr || bus_we !== hold_we) begin
               r3_viol++;
            end
            if (wcnt >= lat) begin
               bit inj;
               inj = (txn == err_at);
               if (txn < 64) begin
                  log_we[txn] = bus_we; log_addr[txn] = bus_addr; log_data[txn] = bus_wdata;
               end
               if (bus_we) begin
                  if (!inj) mem[bus_addr[7:2]] = bus_wdata;
               end else begin
                  bus_rdata = inj ? (32'hE000_0000 | bus_addr) : mem[bus_addr[7:2]];
               end
               if (inj) begin
                  bus_err = 1'b1;
                  if (coll) coll_clr = 1'b1;
               end else begin
                  bus_done = 1'b1;
               end
               txn++;
               wcnt = 0;
            end else begin
               wcnt++;
            end
         end
      end
   end

   task automatic prep(input int l, input int e, input bit c);
      for (int i = 0; i < 64; i++) mem[i] = seed_word(i);
      lat = l; err_at = e; coll = c; txn = 0; r3_viol = 0;
   endtask

   task automatic kick(input logic [31:0] s, input logic [31:0] d,
                       input logic [15:0] ss, input logic [15:0] ds, input logic [15:0] n);
      @(negedge clk);
      cfg_src = s; cfg_dst = d; cfg_src_step = ss; cfg_dst_step = ds; cfg_bytes = n;
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
   endtask

   task automatic wait_end(output bit saw_done);
      saw_done = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (done) begin saw_done = 1'b1; break; end
         if (halted) break;
      end
   endtask

   task automatic do_clear();
      @(negedge clk);
      tb_clr = 1'b1;
      @(posedge clk);
      #1 tb_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1", "req in reset", 32'(bus_req), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "idle flags", {busy, done, halted, src_err, dst_err, bus_req}, 0);
   endtask

   task automatic t_copy(input int l, input logic [31:0] s, input logic [31:0] d,
                         input logic [15:0] ss, input logic [15:0] ds, input int words);
      bit sd;
      prep(l, -1, 0);
      kick(s, d, ss, ds, 16'(words * 4));
      wait_end(sd);
      chk("R4", "done seen", 32'(sd), 1);
      chk("R4", "cnt at done", 32'(desc_cnt), 0);
      chk("R2", "final src", desc_src, s + 32'(words) * {{16{ss[15]}}, ss});
      chk("R2", "final dst", desc_dst, d + 32'(words) * {{16{ds[15]}}, ds});
      chk("R2", "txn count", 32'(txn), 32'(2 * words));
      for (int k = 0; k < words; k++) begin
         logic [31:0] sa, da;
         sa = s + 32'(k) * {{16{ss[15]}}, ss};
         da = d + 32'(k) * {{16{ds[15]}}, ds};
         chk("R2", "read order", {31'(0), log_we[2*k]}, 0);
         chk("R2", "read addr", log_addr[2*k], sa);
         chk("R2", "write addr", log_addr[2*k+1], da);
         chk("R2", "copied word", mem[da[7:2]], seed_word(int'(sa[7:2])));
      end
      chk("R3", "addr/we held while waiting", 32'(r3_viol), 0);
      @(negedge clk);
      chk("R4", "done one cycle", 32'(done), 0);
   endtask

   task automatic t_zero();
      bit sd;
      prep(0, -1, 0);
      kick(32'h0, 32'h80, 16'd4, 16'd4, 16'd0);
      wait_end(sd);
      chk("R4", "zero count done", 32'(sd), 1);
      chk("R4", "zero count no traffic", 32'(txn), 0);
   endtask

   task automatic t_read_err();
      bit sd;
      prep(1, 2, 0);
      kick(32'h0, 32'h80, 16'd4, 16'd4, 16'd12);
      wait_end(sd);
      chk("R5", "halted", 32'(halted), 1);
      chk("R5", "flags", {src_err, dst_err}, 2'b10);
      chk("R5", "txn count", 32'(txn), 4);
      chk("R5", "closing write addr", log_addr[3], 32'h84);
      chk("R5", "closing write data", mem[6'h21], 32'hE000_0004);
      chk("R5", "fault src", desc_src, 32'h4);
      chk("R5", "fault dst", desc_dst, 32'h84);
      chk("R5", "fault cnt", 32'(desc_cnt), 8);
   endtask

   task automatic t_sticky_and_halt_start();
      int t0;
      repeat (8) @(negedge clk);
      chk("R8", "src flag sticky", 32'(src_err), 1);
      t0 = txn;
      kick(32'h10, 32'h90, 16'd4, 16'd4, 16'd4);
      repeat (4) @(negedge clk);
      chk("R9", "start while halted", {halted, bus_req}, 2'b10);
      chk("R9", "no traffic while halted", 32'(txn), 32'(t0));
      do_clear();
      chk("R8", "clear drops flags", {halted, src_err, dst_err}, 0);
   endtask

   task automatic t_write_err();
      bit sd;
      prep(0, 1, 0);
      kick(32'h10, 32'hA0, 16'd4, 16'd4, 16'd12);
      wait_end(sd);
      chk("R6", "halted", 32'(halted), 1);
      chk("R6", "flags", {src_err, dst_err}, 2'b01);
      chk("R6", "txn count", 32'(txn), 3);
      chk("R6", "closing read", {log_we[2], log_addr[2]}, {1'b0, 32'h14});
      chk("R6", "fault src", desc_src, 32'h14);
      chk("R6", "fault dst", desc_dst, 32'hA0);
      chk("R6", "fault cnt", 32'(desc_cnt), 12);
      do_clear();
   endtask

   task automatic t_write_err_last();
      bit sd;
      prep(2, 3, 0);
      kick(32'h40, 32'hC0, 16'd4, 16'd4, 16'd8);
      wait_end(sd);
      chk("R7", "halted", 32'(halted), 1);
      chk("R7", "no closing read", 32'(txn), 4);
      chk("R7", "fault dst", desc_dst, 32'hC4);
      chk("R7", "fault cnt", 32'(desc_cnt), 4);
      chk("R7", "fault src", desc_src, 32'h48);
      do_clear();
   endtask

   task automatic t_collide();
      bit sd;
      prep(0, 0, 1);
      kick(32'h0, 32'h80, 16'd4, 16'd4, 16'd4);
      wait_end(sd);
      chk("R8", "set wins over same-cycle clear", {halted, src_err}, 2'b11);
      coll = 1'b0;
      do_clear();
   endtask

   task automatic t_start_busy();
      bit sd;
      prep(2, -1, 0);
      kick(32'h0, 32'h80, 16'd4, 16'd4, 16'd8);
      repeat (3) @(negedge clk);
      cfg_src = 32'h30; cfg_bytes = 16'd4;
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      wait_end(sd);
      chk("R9", "done after ignored start", 32'(sd), 1);
      chk("R9", "txn count kept", 32'(txn), 4);
      chk("R9", "src kept", desc_src, 32'h8);
   endtask

   initial begin
      t_reset();
      t_copy(0, 32'h0, 32'h80, 16'd4, 16'd4, 4);
      t_copy(3, 32'h20, 32'hFC, 16'd8, 16'hFFFC, 3);
      t_zero();
      t_read_err();
      t_sticky_and_halt_start();
      t_write_err();
      t_write_err_last();
      t_collide();
      t_start_busy();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule